// File: doc/BRIEF.md
# Binary XNOR Popcount Dot-Product Unit

This unit produces one output value of a binarized convolution or fully connected layer. Weights and activations are single bits: a +1 is stored as bit 1 and a -1 as bit 0. Each accepted input slice carries UF weight bits and UF activation bits. The unit compares them lane by lane with XNOR and counts the matching lanes. It adds that count to a running sum.

A vector is a run of slices. The first slice is flagged so that the sum restarts, and the last slice is flagged so that the finished sum is presented with a one-cycle strobe. A per-lane enable mask lets padded or unused lanes drop out of the count. The result is the plain ones count y. A later threshold stage turns it into the signed dot product 2y - N, where N is the number of active terms.

The datapath has two register stages. The first holds the slice count and the second holds the accumulator. A new slice can be accepted on every clock, and consecutive vectors follow each other with no gap.

Top module: `xnor_dot_unit`

## Requirements
- R1: Lane i of an accepted slice contributes 1 when `in_wgt[i]` equals `in_act[i]` (the XNOR of the two bits is 1) and `in_lane_en[i]` is 1. Otherwise it contributes 0.
- R2: The contribution of one slice is the number of contributing lanes across all UF lanes, from 0 to UF.
- R3: A slice accepted with `in_first` = 1 discards the previous running sum, and the sum restarts from that slice's count.
- R4: `out_sum` is the unsigned total of contributions over the slices of the vector, with no 2y - N correction. A vector whose lanes all mismatch gives 0.
- R5: When a slice with `in_last` = 1 is accepted on clock edge k, `out_valid` is 1 for exactly the cycle after edge k+1, provided no last slice is accepted on edge k+1. `out_sum` carries the total in that cycle and holds it until the next result.
- R6: A lane whose `in_lane_en` bit is 0 adds zero, whatever its weight and activation bits are.
- R7: `in_ready` becomes 1 on the first clock edge after reset is released and stays 1. Slices may be accepted on every cycle, and results of back-to-back single-slice vectors come out on consecutive cycles.
- R8: While `rst_n` is 0, `out_valid`, `out_sum` and `in_ready` are 0.
- R9: A vector of NMAX matching, enabled terms reports exactly NMAX, with no wrap-around.
- R10: Cycles with `in_valid` = 0 change neither the running sum nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Slice present |
| in_ready | output | 1 | Unit accepts a slice |
| in_first | input | 1 | Slice starts a vector |
| in_last | input | 1 | Slice ends a vector |
| in_wgt | input | UF | Weight bits, 1 = +1 |
| in_act | input | UF | Activation bits, 1 = +1 |
| in_lane_en | input | UF | Per-lane enable, 0 = lane masked |
| out_valid | output | 1 | One-cycle result strobe |
| out_sum | output | $clog2(NMAX+1) | Ones count of the vector |

## Verification
The bench streams single-slice vectors back to back. A unit that stalled would drop or delay results, and one that kept its sum across vectors would report counts that grow from one vector to the next. Multi-slice vectors with idle gaps check the other accumulation rules. A unit that counted idle cycles, or that failed to clear on the first flag, would return a larger sum, and one that raised the strobe early would pulse in the middle of a vector. Masked lanes and all-mismatch vectors expose a unit that counted disabled lanes or applied the signed correction. A unit that did so would report a non-zero or a wrapped value where 0 is expected. A full NMAX-length vector exposes an accumulator that is too narrow.

// File: rtl/xnor_dot_unit.sv
module xnor_dot_unit #(
  parameter int UF   = 16,
  parameter int NMAX = 1152
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        in_first,
  input  logic                        in_last,
  input  logic [UF-1:0]               in_wgt,
  input  logic [UF-1:0]               in_act,
  input  logic [UF-1:0]               in_lane_en,
  output logic                        out_valid,
  output logic [$clog2(NMAX+1)-1:0]   out_sum
);
  localparam int CW = $clog2(UF + 1);
  localparam int AW = $clog2(NMAX + 1);

  function automatic logic [CW-1:0] ones(input logic [UF-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < UF; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  logic          take;
  logic [UF-1:0] hit;
  logic          s1_v, s1_f, s1_l;
  logic [CW-1:0] s1_cnt;
  logic [AW-1:0] acc, next_sum;

  assign take     = in_valid & in_ready;
  assign hit      = ~(in_wgt ^ in_act) & in_lane_en;
  assign next_sum = (s1_f ? AW'(0) : acc) + AW'(s1_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready  <= 1'b0;
      s1_v      <= 1'b0;
      s1_f      <= 1'b0;
      s1_l      <= 1'b0;
      s1_cnt    <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      in_ready  <= 1'b1;
      s1_v      <= take;
      if (take) begin
        s1_f   <= in_first;
        s1_l   <= in_last;
        s1_cnt <= ones(hit);
      end
      if (s1_v) acc <= next_sum;
      out_valid <= s1_v & s1_l;
      if (s1_v & s1_l) out_sum <= next_sum;
    end
  end

  // R5: strobe follows an accepted last slice by two edges
  p_strobe_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid && in_ready && in_last, 2));

  // R7: ready stays up once reset has been released
  p_ready_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

  // R9: the reported sum never exceeds the largest filter length
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sum <= AW'(NMAX));

  // R3: a one-slice vector cannot carry more than UF
  p_first_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_first && in_last) |=> ##1 (out_sum <= AW'(UF)));

  // R6: a fully masked one-slice vector reports zero
  p_masked_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_first && in_last && in_lane_en == '0)
      |=> ##1 (out_valid && out_sum == '0));
endmodule

// File: tb/sim_xnor_dot_unit.sv
module sim_xnor_dot_unit;
  localparam int UF = 16;
  localparam int NMAX = 1152;
  localparam int AW = $clog2(NMAX + 1);
  localparam int NV = 9;
  // {wgt, act, lane_en, expected count}
  localparam logic [63:0] VEC [NV] = '{
    {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'd16},
    {16'hFFFF, 16'h0000, 16'hFFFF, 16'd0},
    {16'h0000, 16'h0000, 16'hFFFF, 16'd16},
    {16'hAAAA, 16'h5555, 16'hFFFF, 16'd0},
    {16'hAAAA, 16'hAAAA, 16'h00FF, 16'd8},
    {16'hF0F0, 16'hFF00, 16'hFFFF, 16'd8},
    {16'h1234, 16'h1234, 16'h0001, 16'd1},
    {16'h1234, 16'h1234, 16'h0000, 16'd0},
    {16'h0001, 16'h0000, 16'hFFFF, 16'd15}
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_first = 0, in_last = 0;
  logic [UF-1:0] in_wgt = '0, in_act = '0, in_lane_en = '0;
  logic in_ready, out_valid;
  logic [AW-1:0] out_sum;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  xnor_dot_unit #(.UF(UF), .NMAX(NMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_last(in_last), .in_wgt(in_wgt), .in_act(in_act),
    .in_lane_en(in_lane_en), .out_valid(out_valid), .out_sum(out_sum));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [UF-1:0] w, a, en, input logic f, l);
    @(negedge clk);
    in_valid = 1; in_wgt = w; in_act = a; in_lane_en = en; in_first = f; in_last = l;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0;
    in_wgt = 16'h5A5A; in_act = 16'h5A5A; in_lane_en = 16'hFFFF;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_sum == 0, "R8 reset outputs", int'(out_sum), 0);
    check(in_ready == 0, "R8 ready in reset", int'(in_ready), 0);
    rst_n = 1;
    @(negedge clk);
    check(in_ready == 1, "R7 ready after reset", int'(in_ready), 1);

    // back-to-back single-slice vectors: R1 R2 R6 R7
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check(out_valid == 1, "R7 back-to-back strobe", int'(out_valid), 1);
        check(out_sum == AW'(VEC[i-2][15:0]), "R1 R2 R6 slice count",
              int'(out_sum), int'(VEC[i-2][15:0]));
      end
      if (i < NV) begin
        in_valid = 1; in_first = 1; in_last = 1;
        in_wgt = VEC[i][63:48]; in_act = VEC[i][47:32]; in_lane_en = VEC[i][31:16];
      end else begin
        in_valid = 0; in_first = 0; in_last = 0;
      end
    end
    @(negedge clk);
    check(out_valid == 0, "R5 strobe ends", int'(out_valid), 0);

    // multi-slice with idle gaps: 16 + 0 + 8 + 15 = 39 (R10 R3 R5)
    send(16'hFFFF, 16'hFFFF, 16'hFFFF, 1, 0);
    idle(); idle();
    check(out_valid == 0, "R5 no early strobe", int'(out_valid), 0);
    send(16'hFFFF, 16'h0000, 16'hFFFF, 0, 0);
    idle();
    send(16'hAAAA, 16'hAAAA, 16'h00FF, 0, 0);
    send(16'h0001, 16'h0000, 16'hFFFF, 0, 1);
    idle();
    check(out_valid == 0, "R5 one-edge latency not yet", int'(out_valid), 0);
    idle();
    check(out_valid == 1 && out_sum == 39, "R10 gap sum", int'(out_sum), 39);
    idle();
    check(out_valid == 0, "R5 one-cycle pulse", int'(out_valid), 0);
    check(out_sum == 39, "R5 sum held", int'(out_sum), 39);
    repeat (3) idle();
    check(out_sum == 39 && out_valid == 0, "R10 idle no effect", int'(out_sum), 39);

    // new vector restarts: 8 + 1 = 9 (R3)
    send(16'hF0F0, 16'hFF00, 16'hFFFF, 1, 0);
    send(16'h1234, 16'h1234, 16'h0001, 0, 1);
    idle(); idle();
    check(out_valid == 1 && out_sum == 9, "R3 first clears", int'(out_sum), 9);

    // all mismatch over 4 slices gives 0, not -64 (R4)
    for (int s = 0; s < 4; s++) send(16'hFFFF, 16'h0000, 16'hFFFF, s == 0, s == 3);
    idle(); idle();
    check(out_valid == 1 && out_sum == 0, "R4 no signed correction", int'(out_sum), 0);

    // full length of NMAX matching terms (R9)
    for (int s = 0; s < NMAX / UF; s++)
      send(16'hC3C3, 16'hC3C3, 16'hFFFF, s == 0, s == NMAX / UF - 1);
    idle(); idle();
    check(out_valid == 1 && out_sum == AW'(NMAX), "R9 full length", int'(out_sum), NMAX);

    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule